// File: doc/BRIEF.md
# Full-Page Burst Column Sequencer

This block produces the column address stream for one bank of a synchronous DRAM that is running in full-page burst mode. A read or write command loads a start column, and from the next clock the sequencer steps one column per cycle across the 256-column page. Past the last column it continues from column 0, so the burst comes back to its start column and carries on. It never stops by itself. Only a burst-stop or a precharge command ends it. A new read or write command given during a burst restarts the sequence from a new column.

Write bursts also drive a write-enable strobe. That strobe drops in the same cycle in which a burst-stop or precharge command is presented, so no extra write slot follows the stop. The block also watches the time from a bank activation to its precharge. It raises a sticky error flag when that time exceeds a configured limit, but it does not hold off the precharge.

Top module: `fpburst_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `col_o` is 0 and `col_vld_o`, `wr_en_o` and `tras_err_o` are 0.
- R2: A read or write command sampled at a clock edge makes `col_vld_o` 1 and `col_o` equal to the sampled `start_col_i` in the next cycle. `wr_en_o` is 1 in that cycle for a write and 0 for a read.
- R3: While a burst runs and no command arrives, `col_o` rises by exactly 1 each cycle.
- R4: The increment is modulo 256. After 256 accesses the column returns to the start column and the burst goes on without limit.
- R5: A burst-stop sampled at an edge with no read or write makes `col_vld_o` 0 from the next cycle on. A burst-stop while idle has no effect.
- R6: During a write burst, `wr_en_o` is 0 in any cycle in which `stop_i` or `pre_i` is high. This is a zero-cycle write termination.
- R7: A read or write command during a burst reloads the column and restarts the burst as in R2. A read or write takes priority over a burst-stop given in the same cycle.
- R8: A precharge ends a burst in the same way as a burst-stop. A precharge takes priority over a read or write given in the same cycle.
- R9: When `rd_i` and `wr_i` are high together, the burst starts as a write.
- R10: `tras_err_o` rises after the edge that ends activation-to-precharge cycle TRAS_MAX+1 when no precharge has been sampled by then. A precharge sampled exactly TRAS_MAX cycles after the activation leaves it at 0.
- R11: `tras_err_o` stays at 1 until the next `act_i` is sampled, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Bank activated this cycle (starts row-active timing) |
| rd_i | input | 1 | Read command, starts a read burst |
| wr_i | input | 1 | Write command, starts a write burst |
| start_col_i | input | COL_W | Start column for the read or write command |
| stop_i | input | 1 | Burst-stop command |
| pre_i | input | 1 | Precharge command for the bank |
| col_o | output | COL_W | Current column address |
| col_vld_o | output | 1 | Column slot is active this cycle |
| wr_en_o | output | 1 | Write data is captured this cycle |
| tras_err_o | output | 1 | Row-active time limit exceeded (sticky) |

## Verification
The burst is tried from a low start column and stopped after a few beats, which separates correct stepping from a stuck or skipping counter. It is also run from a start column near the page end for more than 256 cycles, which shows a counter that saturates or fails to return to the start column. Commands are given in overlapping pairs (write over read, read with stop, precharge with write, read with write) to check each priority. The activation-to-precharge window is hit exactly at the limit and one cycle past it, which catches an off-by-one in the error flag.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_HALT = 2'd1,
    OP_LOAD = 2'd2
  } fpb_op_e;

  typedef struct packed {
    fpb_op_e op;
    logic    is_wr;
  } fpb_cmd_t;
endpackage

// File: rtl/fpb_cmd_dec.sv
module fpb_cmd_dec
  import fpb_pkg::*;
(
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     stop_i,
  input  logic     pre_i,
  output fpb_cmd_t cmd_o
);
  // priority: precharge, then read/write, then burst-stop
  always_comb begin
    cmd_o.op    = OP_IDLE;
    cmd_o.is_wr = 1'b0;
    if (pre_i) begin
      cmd_o.op = OP_HALT;
    end else if (rd_i || wr_i) begin
      cmd_o.op    = OP_LOAD;
      cmd_o.is_wr = wr_i;
    end else if (stop_i) begin
      cmd_o.op = OP_HALT;
    end
  end
endmodule

// File: rtl/fpb_col_ctr.sv
module fpb_col_ctr
  import fpb_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  fpb_cmd_t         cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  output logic [COL_W-1:0] col_q,
  output logic             busy_q,
  output logic             wrb_q
);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      busy_q <= 1'b0;
      wrb_q  <= 1'b0;
    end else begin
      unique case (cmd_i.op)
        OP_LOAD: begin
          col_q  <= start_col_i;
          busy_q <= 1'b1;
          wrb_q  <= cmd_i.is_wr;
        end
        OP_HALT: begin
          busy_q <= 1'b0;
          wrb_q  <= 1'b0;
        end
        default: begin
          if (busy_q) col_q <= col_q + COL_ONE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpb_tras_mon.sv
module fpb_tras_mon #(
  parameter int TRAS_MAX = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic pre_i,
  output logic err_q
);
  localparam int CNT_W = $clog2(TRAS_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TRAS_MAX);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else if (act_i) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else if (open_q) begin
      if (cnt_q == CNT_LIM) err_q <= 1'b1;
      if (pre_i) open_q <= 1'b0;
      else if (cnt_q != CNT_LIM) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fpburst_seq.sv
module fpburst_seq
  import fpb_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int TRAS_MAX = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  input  logic             pre_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             wr_en_o,
  output logic             tras_err_o
);
  fpb_cmd_t cmd;
  logic     busy, wrb;

  fpb_cmd_dec u_dec (
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .stop_i (stop_i),
    .pre_i  (pre_i),
    .cmd_o  (cmd)
  );

  fpb_col_ctr #(.COL_W(COL_W)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd),
    .start_col_i (start_col_i),
    .col_q       (col_o),
    .busy_q      (busy),
    .wrb_q       (wrb)
  );

  fpb_tras_mon #(.TRAS_MAX(TRAS_MAX)) u_tras (
    .clk   (clk),
    .rst   (rst),
    .act_i (act_i),
    .pre_i (pre_i),
    .err_q (tras_err_o)
  );

  assign col_vld_o = busy;
  // write capture is cut in the very cycle a stop or precharge shows up
  assign wr_en_o   = busy & wrb & ~(stop_i | pre_i);
endmodule

// File: rtl/fpb_chk.sv
module fpb_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             act_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic             pre_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_vld_o,
  input logic             wr_en_o,
  input logic             tras_err_o
);
  AST_LOAD_COL: assert property (@(posedge clk) disable iff (rst)
    ((rd_i || wr_i) && !pre_i) |=> (col_vld_o && col_o == $past(start_col_i))); // R2
  AST_WR_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> col_vld_o); // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && !rd_i && !wr_i && !stop_i && !pre_i)
      |=> (col_vld_o && col_o == COL_W'($past(col_o) + 1'b1))); // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !rd_i && !wr_i) |=> !col_vld_o); // R5
  AST_WR_CUT: assert property (@(posedge clk) disable iff (rst)
    (stop_i || pre_i) |-> !wr_en_o); // R6
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    pre_i |=> !col_vld_o); // R8
  AST_RDWR_IS_WR: assert property (@(posedge clk) disable iff (rst)
    (rd_i && wr_i && !pre_i) |=> (col_vld_o && (wr_en_o || stop_i || pre_i))); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    act_i |=> !tras_err_o); // R11
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tras_err_o && !act_i) |=> tras_err_o); // R11
endmodule

bind fpburst_seq fpb_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .act_i       (act_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .pre_i       (pre_i),
  .col_o       (col_o),
  .col_vld_o   (col_vld_o),
  .wr_en_o     (wr_en_o),
  .tras_err_o  (tras_err_o)
);

// File: tb/fpburst_seq_tb_top.sv
module fpburst_seq_tb_top;
  localparam int COL_W = 8;
  localparam int TMAX  = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst, act, rd, wr, stop, pre;
  logic [COL_W-1:0] start;
  logic [COL_W-1:0] col;
  logic             vld, wen, err;

  fpburst_seq #(.COL_W(COL_W), .TRAS_MAX(TMAX)) dut_i (
    .clk(clk), .rst(rst), .act_i(act), .rd_i(rd), .wr_i(wr),
    .start_col_i(start), .stop_i(stop), .pre_i(pre),
    .col_o(col), .col_vld_o(vld), .wr_en_o(wen), .tras_err_o(err)
  );

  typedef struct {
    logic [COL_W-1:0] col;
    logic             vld;
    logic             wen;
    logic             err;
    string            tag;
  } exp_t;

  exp_t  q[$];
  exp_t  mon_e;
  int    total = 0;
  int    bad   = 0;
  string cur_tag = "R1";

  // expectation state, advanced per the requirements
  logic             m_busy = 1'b0, m_wr = 1'b0, m_open = 1'b0, m_err = 1'b0;
  logic [COL_W-1:0] m_col = '0;
  int               m_cnt = 0;

  task automatic step(input logic a, input logic r, input logic w,
                      input logic s, input logic p, input logic [COL_W-1:0] sc);
    exp_t e;
    @(posedge clk); #1;
    act = a; rd = r; wr = w; stop = s; pre = p; start = sc;
    e.col = m_col; e.vld = m_busy; e.wen = m_busy & m_wr & ~s & ~p;
    e.err = m_err; e.tag = cur_tag;
    q.push_back(e);
    if (p) begin m_busy = 1'b0; m_wr = 1'b0; end
    else if (r || w) begin m_busy = 1'b1; m_wr = w; m_col = sc; end
    else if (s) begin m_busy = 1'b0; m_wr = 1'b0; end
    else if (m_busy) m_col = m_col + 8'd1;
    if (a) begin m_open = 1'b1; m_cnt = 0; m_err = 1'b0; end
    else if (m_open) begin
      if (m_cnt == TMAX) m_err = 1'b1;
      if (p) m_open = 1'b0;
      else if (m_cnt != TMAX) m_cnt = m_cnt + 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      total++;
      if (col !== mon_e.col || vld !== mon_e.vld || wen !== mon_e.wen || err !== mon_e.err) begin
        bad++;
        $display("FAIL %s: got col=%h vld=%b wen=%b err=%b exp col=%h vld=%b wen=%b err=%b",
                 mon_e.tag, col, vld, wen, err, mon_e.col, mon_e.vld, mon_e.wen, mon_e.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung exp finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; act = 0; rd = 0; wr = 0; stop = 0; pre = 0; start = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (col !== 8'h00 || vld !== 1'b0 || wen !== 1'b0 || err !== 1'b0) begin
      bad++;
      $display("FAIL R1: got col=%h vld=%b wen=%b err=%b exp 00 0 0 0", col, vld, wen, err);
    end
    @(posedge clk); #1 rst = 1'b0;
    cur_tag = "R1"; idle(2);
    // write burst, then stop: R2 R3 R6 R5
    cur_tag = "R2"; step(0, 0, 1, 0, 0, 8'h10);
    cur_tag = "R3"; idle(5);
    cur_tag = "R6"; step(0, 0, 0, 1, 0, 8'h00);
    cur_tag = "R5"; idle(3);
    step(0, 0, 0, 1, 0, 8'h00); idle(2);
    // long read burst near the page end: R4
    cur_tag = "R4"; step(0, 1, 0, 0, 0, 8'hF0);
    idle(300);
    step(0, 0, 0, 1, 0, 8'h00); idle(2);
    // reload mid-burst, and command over stop: R7
    cur_tag = "R7"; step(0, 1, 0, 0, 0, 8'h20); idle(4);
    step(0, 0, 1, 0, 0, 8'h40); idle(3);
    step(0, 1, 0, 1, 0, 8'h80); idle(3);
    step(0, 0, 0, 1, 0, 8'h00); idle(1);
    // precharge ends burst, beats a command: R8 R6
    cur_tag = "R8"; step(0, 0, 1, 0, 0, 8'h33); idle(3);
    step(0, 0, 0, 0, 1, 8'h00); idle(2);
    step(0, 0, 1, 0, 0, 8'h50); idle(2);
    step(0, 1, 0, 0, 1, 8'h60); idle(3);
    // read and write together: R9
    cur_tag = "R9"; step(0, 1, 1, 0, 0, 8'hA5); idle(3);
    step(0, 0, 0, 1, 0, 8'h00); idle(1);
    // row-active limit: R10
    cur_tag = "R10"; step(1, 0, 0, 0, 0, 8'h00); idle(TMAX - 1);
    step(0, 0, 0, 0, 1, 8'h00); idle(3);
    step(1, 0, 0, 0, 0, 8'h00); idle(TMAX + 5);
    // sticky until next activation: R11
    cur_tag = "R11"; step(0, 0, 0, 0, 1, 8'h00); idle(5);
    step(1, 0, 0, 0, 0, 8'h00); idle(3);
    step(0, 0, 0, 0, 1, 8'h00); idle(2);
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule